// File: doc/BRIEF.md
# Multi-channel general-purpose timer

This block is a bank of up to six independent up-counting timer channels behind a simple word-addressed register port. Each channel has four registers: control, clock select, count and compare. The control register enables the channel, picks one of its operating modes and can zero the counter. The clock-select register chooses between the block's own clock and an external slow tick-enable, and can halve that rate. The count register can be read at any time. The compare register sets the value that raises the channel's interrupt request.

A match against the compare value sets the channel's pending bit. In one-shot mode the channel then stops. In repeat mode it starts counting again from zero. A free-running channel never matches. A shared enable register and a shared write-one-to-acknowledge register each hold one bit per channel. A single interrupt line is raised while any enabled channel is pending. Register writes take effect at the clock edge on which `wrEn` is sampled high. Reads are combinational from `addr`.

Top module: `gpt_timer_bank`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: The interrupt enable register is at 0x00 and the pending/acknowledge register is at 0x08. Bit n-1 of each belongs to channel n. Channel n has control at 0x10*n, clock select at 0x10*n+0x4, count at 0x10*n+0x8 and compare at 0x10*n+0xC. Writes to a count register are ignored. Other addresses read 0.
- R3: In the control register, bit 0 enables the channel and bits 5:4 select the mode (0 one-shot, 1 repeat, 2 or 3 free-running). Bit 1 always reads 0. The counter does not advance in a cycle in which its control register is written.
- R4: In the clock-select register, bit 4 picks the source: 0 counts on every clock and 1 counts on cycles where `slowTick` is high. With bit 0 set, only every second qualifying tick advances the counter. Writing the clock-select register restarts that halving phase.
- R5: One-shot: an advancing tick with count equal to compare sets the pending bit and clears the enable bit, and the count holds its value.
- R6: Repeat: an advancing tick with count equal to compare sets the pending bit and sets the count to 0. The channel stays enabled, so the period is compare+1 advancing ticks.
- R7: Free-running: the count increments modulo 2^32 and never sets the pending bit.
- R8: Writing control with bit 1 set makes the count 0 on the next cycle and restarts the halving phase.
- R9: Writing 1 to a bit of 0x08 clears that pending bit. Bits written as 0 have no effect. A match in the same cycle keeps its bit set.
- R10: `irq` is high exactly when some channel has both its pending bit and its enable bit set. A pending bit latches even while its enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the fast count source |
| rstN | input | 1 | Asynchronous active-low reset |
| slowTick | input | 1 | One-cycle tick enable of the slow source |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench attacks the ordering of a match against the stop and the reload. A one-shot channel that ran past its compare value, or a repeat channel with the wrong period, shows up as a count that diverges from the model within a few cycles. The halving phase is exercised with both sources and with mid-run clock-select writes; a divider that ignores the phase restart drifts by one tick. A pending bit that latches only while enabled, or an acknowledge that also clears bits written as zero, makes `irq` or the pending readback differ. A clear bit that is stored instead of acting once reads back as 1 and keeps the counter pinned at 0.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  parameter int DATA_W = 32;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_CLR_BIT = 1;
  localparam int CTRL_MODE_LO = 4;
  localparam int CLK_DIV_BIT  = 0;
  localparam int CLK_SRC_BIT  = 4;

  typedef enum logic [1:0] {
    MODE_ONCE = 2'd0,
    MODE_LOOP = 2'd1,
    MODE_ALT  = 2'd2,
    MODE_FREE = 2'd3
  } runMode_t;

  typedef struct packed {
    logic wrCtrl;
    logic wrClk;
    logic wrCmp;
  } chStrobe_t;
endpackage

// File: rtl/gpt_channel.sv
module gpt_channel
  import gpt_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         slowTick,
  input  chStrobe_t    strobe,
  input  logic [W-1:0] wrData,
  output logic         hit,
  output logic [3:0][W-1:0] regView
);
  logic         en;
  runMode_t     mode;
  logic         srcSlow;
  logic         halve;
  logic         phase;
  logic [W-1:0] count;
  logic [W-1:0] compare;

  logic srcTick, step, atCompare, matching;

  assign srcTick   = srcSlow ? slowTick : 1'b1;
  assign step      = !halve || phase;
  assign atCompare = (mode == MODE_ONCE || mode == MODE_LOOP) && (count == compare);
  assign matching  = en && srcTick && step && atCompare;
  assign hit       = matching && !strobe.wrCtrl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en      <= 1'b0;
      mode    <= MODE_ONCE;
      srcSlow <= 1'b0;
      halve   <= 1'b0;
      phase   <= 1'b0;
      count   <= '0;
      compare <= '0;
    end else begin
      if (strobe.wrCtrl) begin
        en   <= wrData[CTRL_EN_BIT];
        mode <= runMode_t'(wrData[CTRL_MODE_LO +: 2]);
        if (wrData[CTRL_CLR_BIT]) begin
          count <= '0;
          phase <= 1'b0;
        end
      end else if (en && srcTick) begin
        if (halve) phase <= !phase;
        if (step) begin
          if (atCompare) begin
            if (mode == MODE_ONCE) en <= 1'b0;
            else count <= '0;
          end else begin
            count <= count + 1'b1;
          end
        end
      end
      if (strobe.wrClk) begin
        srcSlow <= wrData[CLK_SRC_BIT];
        halve   <= wrData[CLK_DIV_BIT];
        phase   <= 1'b0;
      end
      if (strobe.wrCmp) compare <= wrData;
    end
  end

  always_comb begin
    regView = '0;
    regView[0][CTRL_EN_BIT]         = en;
    regView[0][CTRL_MODE_LO +: 2]   = mode;
    regView[1][CLK_SRC_BIT]         = srcSlow;
    regView[1][CLK_DIV_BIT]         = halve;
    regView[2]                      = count;
    regView[3]                      = compare;
  end
endmodule

// File: rtl/gpt_datapath.sv
module gpt_datapath
  import gpt_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int W      = DATA_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          slowTick,
  input  chStrobe_t [NUM_CH-1:0]        strobes,
  input  logic [W-1:0]                  wrData,
  output logic [NUM_CH-1:0]             hitVec,
  output logic [NUM_CH-1:0][3:0][W-1:0] chRead
);
  for (genvar c = 0; c < NUM_CH; c++) begin : gChan
    gpt_channel #(.W(W)) uChan (
      .clk      (clk),
      .rstN     (rstN),
      .slowTick (slowTick),
      .strobe   (strobes[c]),
      .wrData   (wrData),
      .hit      (hitVec[c]),
      .regView  (chRead[c])
    );
  end
endmodule

// File: rtl/gpt_ctrl.sv
module gpt_ctrl
  import gpt_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 8,
  parameter int W      = DATA_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [W-1:0]                  wrData,
  input  logic [NUM_CH-1:0]             hitVec,
  input  logic [NUM_CH-1:0][3:0][W-1:0] chRead,
  output chStrobe_t [NUM_CH-1:0]        strobes,
  output logic [W-1:0]                  rdData,
  output logic                          irq
);
  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0]  chIdx;
  logic [1:0]        regSel;
  logic [NUM_CH-1:0] irqEnable;
  logic [NUM_CH-1:0] pending;
  logic [NUM_CH-1:0] ackMask;
  logic              globalPage;

  assign chIdx      = addr[ADDR_W-1:4];
  assign regSel     = addr[3:2];
  assign globalPage = (chIdx == '0);
  assign ackMask    = (wrEn && globalPage && regSel == 2'd2) ? wrData[NUM_CH-1:0] : '0;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      strobes[c] = '0;
      if (wrEn && int'(chIdx) == c + 1) begin
        strobes[c].wrCtrl = (regSel == 2'd0);
        strobes[c].wrClk  = (regSel == 2'd1);
        strobes[c].wrCmp  = (regSel == 2'd3);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEnable <= '0;
      pending   <= '0;
    end else begin
      if (wrEn && globalPage && regSel == 2'd0) irqEnable <= wrData[NUM_CH-1:0];
      pending <= (pending & ~ackMask) | hitVec;
    end
  end

  always_comb begin
    rdData = '0;
    if (globalPage) begin
      if (regSel == 2'd0) rdData[NUM_CH-1:0] = irqEnable;
      else if (regSel == 2'd2) rdData[NUM_CH-1:0] = pending;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (int'(chIdx) == c + 1) rdData = chRead[c][regSel];
      end
    end
  end

  assign irq = |(pending & irqEnable);
endmodule

// File: rtl/gpt_timer_bank.sv
module gpt_timer_bank
  import gpt_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam int MAX_CH = (1 << (ADDR_W - 4)) - 1;

  initial begin
    if (NUM_CH < 1 || NUM_CH > MAX_CH) $error("NUM_CH out of range for ADDR_W");
  end

  chStrobe_t [NUM_CH-1:0]             strobes;
  logic [NUM_CH-1:0]                  hitVec;
  logic [NUM_CH-1:0][3:0][DATA_W-1:0] chRead;

  gpt_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .W(DATA_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .wrData  (wrData),
    .hitVec  (hitVec),
    .chRead  (chRead),
    .strobes (strobes),
    .rdData  (rdData),
    .irq     (irq)
  );

  gpt_datapath #(.NUM_CH(NUM_CH), .W(DATA_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .slowTick (slowTick),
    .strobes  (strobes),
    .wrData   (wrData),
    .hitVec   (hitVec),
    .chRead   (chRead)
  );
endmodule

// File: rtl/gpt_timer_checker.sv
module gpt_timer_checker
  import gpt_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 8
) (
  input logic                               clk,
  input logic                               rstN,
  input logic                               wrEn,
  input logic [ADDR_W-1:0]                  addr,
  input logic [DATA_W-1:0]                  wrData,
  input logic                               irq,
  input logic [NUM_CH-1:0]                  hitVec,
  input logic [NUM_CH-1:0][3:0][DATA_W-1:0] chRead,
  input chStrobe_t [NUM_CH-1:0]             strobes
);
  assert_ack_all_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h08 && wrData[NUM_CH-1:0] == {NUM_CH{1'b1}} && hitVec == '0) |=> !irq);

  for (genvar c = 0; c < NUM_CH; c++) begin : gChk
    assert_free_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
      hitVec[c] |-> !chRead[c][0][CTRL_MODE_LO + 1]);

    assert_once_stops_R5: assert property (@(posedge clk) disable iff (!rstN)
      (hitVec[c] && chRead[c][0][CTRL_MODE_LO +: 2] == 2'd0) |=> !chRead[c][0][CTRL_EN_BIT]);

    assert_loop_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
      (hitVec[c] && chRead[c][0][CTRL_MODE_LO +: 2] == 2'd1) |=> chRead[c][2] == '0);

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[c].wrCtrl && wrData[CTRL_CLR_BIT]) |=> chRead[c][2] == '0);

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!chRead[c][0][CTRL_EN_BIT] && !strobes[c].wrCtrl) |=> $stable(chRead[c][2]));

    assert_clr_reads_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
      !chRead[c][0][CTRL_CLR_BIT]);
  end
endmodule

bind gpt_timer_bank gpt_timer_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrData  (wrData),
  .irq     (irq),
  .hitVec  (hitVec),
  .chRead  (chRead),
  .strobes (strobes)
);

// File: tb/tb_gpt_timer_bank.sv
`timescale 1ns/100ps
module tb_gpt_timer_bank;
  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowTick = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int total = 0;
  int bad = 0;
  string curReq = "R1";
  bit finished = 0;

  gpt_timer_bank dut (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #2 clk = ~clk;

  // behavioural reference model
  logic        mEn   [NCH];
  logic [1:0]  mMode [NCH];
  logic        mSrc  [NCH];
  logic        mDiv  [NCH];
  logic        mPh   [NCH];
  logic [31:0] mCnt  [NCH];
  logic [31:0] mCmp  [NCH];
  logic [NCH-1:0] mPend, mIen;

  always @(posedge clk) begin
    logic [NCH-1:0] hits;
    hits = '0;
    if (!rstN) begin
      for (int i = 0; i < NCH; i++) begin
        mEn[i] = 0; mMode[i] = 0; mSrc[i] = 0; mDiv[i] = 0; mPh[i] = 0;
        mCnt[i] = 0; mCmp[i] = 0;
      end
      mPend = '0; mIen = '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        int base;
        bit tick, adv;
        base = 16 * (i + 1);
        tick = mSrc[i] ? slowTick : 1'b1;
        if (wrEn && addr == base[7:0]) begin
          mEn[i] = wrData[0];
          mMode[i] = wrData[5:4];
          if (wrData[1]) begin mCnt[i] = 0; mPh[i] = 0; end
        end else if (mEn[i] && tick) begin
          adv = 1;
          if (mDiv[i]) begin
            adv = mPh[i];
            mPh[i] = !mPh[i];
          end
          if (adv) begin
            if (mCnt[i] == mCmp[i] && mMode[i] == 0) begin
              hits[i] = 1; mEn[i] = 0;
            end else if (mCnt[i] == mCmp[i] && mMode[i] == 1) begin
              hits[i] = 1; mCnt[i] = 0;
            end else begin
              mCnt[i] = mCnt[i] + 1;
            end
          end
        end
        if (wrEn && addr == base[7:0] + 8'h04) begin
          mSrc[i] = wrData[4]; mDiv[i] = wrData[0]; mPh[i] = 0;
        end
        if (wrEn && addr == base[7:0] + 8'h0C) mCmp[i] = wrData;
      end
      if (wrEn && addr == 8'h08) mPend = mPend & ~wrData[NCH-1:0];
      mPend = mPend | hits;
      if (wrEn && addr == 8'h00) mIen = wrData[NCH-1:0];
    end
  end

  function automatic logic [31:0] mRead(logic [7:0] a);
    int ch, s;
    logic [31:0] v;
    ch = int'(a[7:4]);
    s  = int'(a[3:2]);
    v  = '0;
    if (ch == 0) begin
      if (s == 0) v[NCH-1:0] = mIen;
      else if (s == 2) v[NCH-1:0] = mPend;
    end else if (ch <= NCH) begin
      case (s)
        0: begin v[0] = mEn[ch-1]; v[5:4] = mMode[ch-1]; end
        1: begin v[4] = mSrc[ch-1]; v[0] = mDiv[ch-1]; end
        2: v = mCnt[ch-1];
        default: v = mCmp[ch-1];
      endcase
    end
    return v;
  endfunction

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      total++;
      if (irq !== |(mPend & mIen)) begin
        bad++;
        $display("FAIL R10 irq actual=%0b expected=%0b", irq, |(mPend & mIen));
      end
      total++;
      if (rdData !== mRead(addr)) begin
        bad++;
        $display("FAIL %s rdData addr=%h actual=%h expected=%h", curReq, addr, rdData, mRead(addr));
      end
    end
  end

  // slow source: one-cycle pulse every seventh clock
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      slowTick = (cyc % 7 == 0);
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wrEn = 1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 0;
  endtask

  task automatic look(logic [7:0] a);
    addr = a;
    @(posedge clk); #1;
  endtask

  task automatic peek(logic [7:0] a, logic [31:0] exp, string req);
    addr = a;
    #0.5;
    total++;
    if (rdData !== exp) begin
      bad++;
      $display("FAIL %s peek addr=%h actual=%h expected=%h", req, a, rdData, exp);
    end
  endtask

  task automatic peekIrq(logic exp, string req);
    #0.2;
    total++;
    if (irq !== exp) begin
      bad++;
      $display("FAIL %s irq actual=%0b expected=%0b", req, irq, exp);
    end
  endtask

  initial begin
    logic [31:0] held;
    #10;
    @(posedge clk); #1;
    rstN = 1;
    // R1 reset state
    curReq = "R1";
    peek(8'h10, 32'h0, "R1");
    peek(8'h08, 32'h0, "R1");
    peek(8'h3C, 32'h0, "R1");
    peekIrq(1'b0, "R1");
    idle(1);

    // R6 repeat mode on channel 1, R3 clear bit reads 0
    curReq = "R6";
    wr(8'h1C, 32'd5);
    wr(8'h00, 32'h01);
    wr(8'h10, 32'h13);
    peek(8'h10, 32'h11, "R3");
    idle(1);
    look(8'h18);
    idle(25);
    peek(8'h08, 32'h01, "R6");
    idle(1);

    // R9 ack with zeros then with one, after stopping channel 1
    curReq = "R9";
    wr(8'h10, 32'h10);
    wr(8'h08, 32'h00);
    peek(8'h08, 32'h01, "R9");
    wr(8'h08, 32'h01);
    peek(8'h08, 32'h00, "R9");
    peekIrq(1'b0, "R9");
    idle(1);

    // R5 one-shot with halving on channel 2, R4
    curReq = "R5";
    wr(8'h2C, 32'd3);
    wr(8'h24, 32'h01);
    wr(8'h20, 32'h03);
    look(8'h28);
    idle(20);
    peek(8'h20, 32'h00, "R5");
    peek(8'h28, 32'd3, "R5");
    peek(8'h08, 32'h02, "R5");
    idle(1);

    // R4 halving phase restart mid-run, fast source
    curReq = "R4";
    wr(8'h2C, 32'd40);
    wr(8'h20, 32'h13);
    look(8'h28);
    idle(5);
    wr(8'h24, 32'h01);
    look(8'h28);
    idle(7);
    wr(8'h24, 32'h00);
    look(8'h28);
    idle(6);
    wr(8'h20, 32'h10);

    // R7 free-running channel 3 on halved slow source
    curReq = "R7";
    wr(8'h3C, 32'd2);
    wr(8'h34, 32'h11);
    wr(8'h30, 32'h31);
    look(8'h38);
    idle(80);
    peek(8'h08, 32'h02, "R7");
    idle(1);

    // R8 clear while running
    curReq = "R8";
    wr(8'h30, 32'h33);
    peek(8'h38, 32'h0, "R8");
    idle(30);

    // R10 pending latches while masked, then enable exposes it
    curReq = "R10";
    wr(8'h6C, 32'd1);
    wr(8'h60, 32'h03);
    look(8'h08);
    idle(6);
    peek(8'h08, 32'h22, "R10");
    peekIrq(1'b0, "R10");
    idle(1);
    wr(8'h00, 32'h20);
    peekIrq(1'b1, "R10");
    idle(1);

    // R9 acknowledge everything
    curReq = "R9";
    wr(8'h08, 32'h3f);
    peek(8'h08, 32'h00, "R9");
    peekIrq(1'b0, "R9");
    idle(1);

    // R2 count is read-only, unmapped addresses read zero
    curReq = "R2";
    look(8'h18);
    held = rdData;
    wr(8'h18, 32'h55);
    peek(8'h18, held, "R2");
    peek(8'h04, 32'h0, "R2");
    peek(8'h70, 32'h0, "R2");
    peek(8'h0C, 32'h0, "R2");
    peek(8'h00, 32'h20, "R2");
    idle(3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule